// File: doc/BRIEF.md
# Pseudoinstruction Expansion Sequencer

This block turns one assembler shorthand command into the real 32-bit machine words that carry it out. A command arrives on a valid/ready input and names one of four operations (register copy, load of a constant, load of an already resolved address, or rotate right), together with a destination register, a source register and a 32-bit operand. The block then emits the matching words, one per cycle, on a valid/ready output stream. A last flag marks the final word of each expansion.

Constants and addresses that survive sign extension from 16 bits become a single add-immediate word. Wider values become a load-upper word followed by an or-immediate word. Rotate right always produces three words and passes the shifted-out part through scratch register 1. A new command is refused while an expansion is still being sent. The one exception is the cycle in which the final word is taken: a new command can be accepted there, so expansions can follow each other with no idle cycle.

Top module: `pseudo_expander`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1.
- R2: A copy command (in_op=0) emits one word with last=1: opcode 0, rs=0, rt=in_rs, rd=in_rd, shamt=0, funct 32.
- R3: A constant load (in_op=1) whose value has bits 31:15 all equal emits one word with last=1: opcode 8, rs=0, rt=in_rd, immediate = value bits 15:0.
- R4: A constant load with a wider value emits two words. The first has last=0: opcode 0x0F, rs=0, rt=in_rd, immediate = value bits 31:16. The second has last=1: opcode 0x0D, rs=in_rd, rt=in_rd, immediate = value bits 15:0.
- R5: An address load (in_op=2) follows exactly the one-word and two-word rules of R3 and R4.
- R6: A rotate (in_op=3) by amount a = value bits 4:0 emits three words, with last=1 only on the third. The words are: srl (opcode 0, rs=0, rt=in_rd, rd=1, shamt=a, funct 2), then sll (rt=in_rd, rd=in_rd, shamt=(32-a) mod 32, funct 0), then or (rs=in_rd, rt=1, rd=in_rd, funct 37).
- R7: For a rotate, value bits 31:5 have no effect. An amount of 0 gives an sll shamt of 0.
- R8: While out_valid=1 and out_ready=0, out_valid, out_word and out_last hold their values into the next cycle.
- R9: in_ready is 0 while out_valid=1, except in a cycle where out_ready=1 and out_last=1. When out_valid=0, in_ready is 1.
- R10: With out_ready held at 1, the words of one expansion leave on consecutive cycles, starting the cycle after the command is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A command is offered |
| in_ready | output | 1 | A command can be taken this cycle |
| in_op | input | 2 | 0 copy, 1 constant load, 2 address load, 3 rotate right |
| in_rd | input | 5 | Destination register (also the rotated register) |
| in_rs | input | 5 | Source register of a copy |
| in_value | input | 32 | Constant, resolved address, or rotate amount in bits 4:0 |
| out_valid | output | 1 | A machine word is offered |
| out_ready | input | 1 | The consumer takes the word this cycle |
| out_word | output | 32 | Machine word |
| out_last | output | 1 | This word ends the expansion |

## Verification
Two functions can fall in the same cycle: the final word of one expansion is handed off, and the next command is accepted. The bench provokes this by keeping in_valid high with the next command while the output consumer holds out_ready high. It also runs phases in which out_ready follows a pseudo-random pattern. The scoreboard judges the result by the exact order of the words and last flags, with no word lost or repeated. It also checks that in_ready rises in exactly the handoff cycle and that the next expansion starts on the following cycle.

// File: rtl/pxp_pkg.sv
package pxp_pkg;

   typedef enum logic [1:0] {
      PX_COPY  = 2'd0,
      PX_LDIMM = 2'd1,
      PX_LDADR = 2'd2,
      PX_ROTR  = 2'd3
   } px_op_e;

   localparam logic [5:0] OPC_RTYPE = 6'd0;
   localparam logic [5:0] OPC_ADDI  = 6'd8;
   localparam logic [5:0] OPC_ORI   = 6'h0D;
   localparam logic [5:0] OPC_LUI   = 6'h0F;
   localparam logic [5:0] FN_SLL    = 6'h00;
   localparam logic [5:0] FN_SRL    = 6'h02;
   localparam logic [5:0] FN_ADD    = 6'd32;
   localparam logic [5:0] FN_OR     = 6'd37;

   function automatic logic [31:0] r_word(input logic [4:0] rs, input logic [4:0] rt,
                                          input logic [4:0] rd, input logic [4:0] sh,
                                          input logic [5:0] fn);
      return {OPC_RTYPE, rs, rt, rd, sh, fn};
   endfunction

   function automatic logic [31:0] i_word(input logic [5:0] opc, input logic [4:0] rs,
                                          input logic [4:0] rt, input logic [15:0] imm);
      return {opc, rs, rt, imm};
   endfunction

endpackage

// File: rtl/pxp_decode.sv
module pxp_decode
   import pxp_pkg::*;
#(
   parameter int WORD_W  = 32,
   parameter int REG_W   = 5,
   parameter int MAX_SEQ = 3,
   parameter int SCRATCH = 1,
   parameter int IDX_W   = 2
) (
   input  px_op_e                          op,
   input  logic [REG_W-1:0]                dst,
   input  logic [REG_W-1:0]                src,
   input  logic [WORD_W-1:0]               val,
   output logic [MAX_SEQ-1:0][WORD_W-1:0]  words,
   output logic [IDX_W-1:0]                last_idx
);
   localparam int HALF_W = WORD_W / 2;
   localparam logic [REG_W-1:0] ZERO_R = '0;
   localparam logic [REG_W-1:0] TMP_R  = REG_W'(SCRATCH);

   logic              fits;
   logic [REG_W-1:0]  amt;
   logic [REG_W-1:0]  lsh;

   always_comb begin
      fits = (&val[WORD_W-1:HALF_W-1]) | ~(|val[WORD_W-1:HALF_W-1]);
      amt  = val[REG_W-1:0];
      lsh  = REG_W'((REG_W+1)'(WORD_W) - {1'b0, amt});
   end

   always_comb begin
      words    = '0;
      last_idx = '0;
      unique case (op)
         PX_COPY: begin
            words[0] = r_word(ZERO_R, src, dst, 5'd0, FN_ADD);
         end
         PX_LDIMM, PX_LDADR: begin
            if (fits) begin
               words[0] = i_word(OPC_ADDI, ZERO_R, dst, val[HALF_W-1:0]);
            end else begin
               words[0] = i_word(OPC_LUI, ZERO_R, dst, val[WORD_W-1:HALF_W]);
               words[1] = i_word(OPC_ORI, dst, dst, val[HALF_W-1:0]);
               last_idx = IDX_W'(1);
            end
         end
         PX_ROTR: begin
            words[0] = r_word(ZERO_R, dst, TMP_R, amt, FN_SRL);
            words[1] = r_word(ZERO_R, dst, dst, lsh, FN_SLL);
            words[2] = r_word(dst, TMP_R, dst, 5'd0, FN_OR);
            last_idx = IDX_W'(2);
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/pxp_seq.sv
module pxp_seq #(
   parameter int WORD_W  = 32,
   parameter int MAX_SEQ = 3,
   parameter int IDX_W   = 2
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          load,
   input  logic [MAX_SEQ-1:0][WORD_W-1:0] load_words,
   input  logic [IDX_W-1:0]              load_last,
   input  logic                          out_ready,
   output logic                          out_valid,
   output logic [WORD_W-1:0]             out_word,
   output logic                          out_last,
   output logic                          done
);
   logic [MAX_SEQ-1:0][WORD_W-1:0] slot_q;
   logic [IDX_W-1:0]               idx_q;
   logic [IDX_W-1:0]               end_q;
   logic                           busy_q;
   logic                           step;

   assign step = busy_q & out_ready;

   for (genvar g = 0; g < MAX_SEQ; g++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    slot_q[g] <= '0;
         else if (load) slot_q[g] <= load_words[g];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q  <= '0;
         end_q  <= '0;
         busy_q <= 1'b0;
      end else if (load) begin
         idx_q  <= '0;
         end_q  <= load_last;
         busy_q <= 1'b1;
      end else if (step) begin
         if (idx_q == end_q) busy_q <= 1'b0;
         else                idx_q  <= idx_q + 1'b1;
      end
   end

   always_comb begin
      out_valid = busy_q;
      out_word  = slot_q[idx_q];
      out_last  = busy_q & (idx_q == end_q);
      done      = step & (idx_q == end_q);
   end
endmodule

// File: rtl/pseudo_expander.sv
module pseudo_expander
   import pxp_pkg::*;
#(
   parameter int WORD_W  = 32,
   parameter int REG_W   = 5,
   parameter int MAX_SEQ = 3,
   parameter int SCRATCH = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [1:0]        in_op,
   input  logic [REG_W-1:0]  in_rd,
   input  logic [REG_W-1:0]  in_rs,
   input  logic [WORD_W-1:0] in_value,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [WORD_W-1:0] out_word,
   output logic              out_last
);
   localparam int IDX_W = (MAX_SEQ > 1) ? $clog2(MAX_SEQ) : 1;

   if (WORD_W != 32) begin : g_bad_word
      $error("pseudo_expander: WORD_W must be 32");
   end
   if (REG_W != 5) begin : g_bad_reg
      $error("pseudo_expander: REG_W must be 5");
   end
   if (MAX_SEQ < 3) begin : g_bad_seq
      $error("pseudo_expander: MAX_SEQ must hold a three-word rotate");
   end
   if (SCRATCH < 1 || SCRATCH >= (1 << REG_W)) begin : g_bad_tmp
      $error("pseudo_expander: SCRATCH must be a nonzero register");
   end

   logic [MAX_SEQ-1:0][WORD_W-1:0] dec_words;
   logic [IDX_W-1:0]               dec_last;
   logic                           seq_done;
   logic                           accept;

   pxp_decode #(
      .WORD_W(WORD_W), .REG_W(REG_W), .MAX_SEQ(MAX_SEQ),
      .SCRATCH(SCRATCH), .IDX_W(IDX_W)
   ) u_decode (
      .op(px_op_e'(in_op)), .dst(in_rd), .src(in_rs), .val(in_value),
      .words(dec_words), .last_idx(dec_last)
   );

   pxp_seq #(
      .WORD_W(WORD_W), .MAX_SEQ(MAX_SEQ), .IDX_W(IDX_W)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .load(accept),
      .load_words(dec_words), .load_last(dec_last),
      .out_ready(out_ready), .out_valid(out_valid),
      .out_word(out_word), .out_last(out_last), .done(seq_done)
   );

   assign in_ready = ~out_valid | seq_done;
   assign accept   = in_valid & in_ready;
endmodule

// File: rtl/pxp_checker.sv
module pxp_checker (
   input logic        clk,
   input logic        rst_n,
   input logic        in_valid,
   input logic        in_ready,
   input logic [1:0]  in_op,
   input logic        out_valid,
   input logic        out_ready,
   input logic [31:0] out_word,
   input logic        out_last
);
   AST_HOLD_WORD: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_word) && $stable(out_last)); // R8

   AST_NO_EARLY_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !(out_ready && out_last) |-> !in_ready); // R9

   AST_IDLE_READY: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> in_ready); // R9

   AST_START_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready |=> out_valid); // R10

   AST_COPY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready && in_op == 2'd0 |=> out_last && out_word[31:26] == 6'd0
                                                && out_word[5:0] == 6'd32); // R2

   AST_UPPER_NOT_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_word[31:26] == 6'h0F |-> !out_last); // R4

   AST_ROTATE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready && in_op == 2'd3 |=> !out_last && out_word[31:26] == 6'd0
                                                && out_word[5:0] == 6'd2
                                                && out_word[15:11] == 5'd1); // R6
endmodule

bind pseudo_expander pxp_checker u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
   .in_op(in_op), .out_valid(out_valid), .out_ready(out_ready),
   .out_word(out_word), .out_last(out_last)
);

// File: tb/pseudo_expander_bench.sv
module pseudo_expander_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [1:0]  in_op = '0;
   logic [4:0]  in_rd = '0;
   logic [4:0]  in_rs = '0;
   logic [31:0] in_value = '0;
   logic        out_valid;
   logic        out_ready = 1'b1;
   logic [31:0] out_word;
   logic        out_last;

   int n_tests = 0;
   int n_fail  = 0;
   bit finished = 1'b0;
   int rdy_mode = 0;
   logic [15:0] lfsr = 16'hACE1;

   logic [32:0] exp_q[$];
   string       tag_q[$];

   always #5 clk = ~clk;

   pseudo_expander u_pseudo_expander (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_op(in_op), .in_rd(in_rd), .in_rs(in_rs), .in_value(in_value),
      .out_valid(out_valid), .out_ready(out_ready),
      .out_word(out_word), .out_last(out_last)
   );

   task automatic chk(input bit ok, input string tag, input logic [32:0] act,
                      input logic [32:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] rw(input logic [4:0] rs, input logic [4:0] rt,
                                      input logic [4:0] rd, input logic [4:0] sh,
                                      input logic [5:0] fn);
      return {6'd0, rs, rt, rd, sh, fn};
   endfunction

   function automatic logic [31:0] iw(input logic [5:0] opc, input logic [4:0] rs,
                                      input logic [4:0] rt, input logic [15:0] imm);
      return {opc, rs, rt, imm};
   endfunction

   task automatic push(input logic [31:0] w, input bit last, input string tag);
      exp_q.push_back({last, w});
      tag_q.push_back(tag);
   endtask

   task automatic send(input logic [1:0] op, input logic [4:0] rd, input logic [4:0] rs,
                       input logic [31:0] v);
      bit got;
      bit fits;
      logic [4:0] a;
      string tg;
      fits = (v[31:15] == 17'h1FFFF) || (v[31:15] == 17'h0);
      a = v[4:0];
      tg = (op == 2'd2) ? "R5" : (fits ? "R3" : "R4");
      case (op)
         2'd0: push(rw(5'd0, rs, rd, 5'd0, 6'd32), 1'b1, "R2");
         2'd1, 2'd2: begin
            if (fits) push(iw(6'd8, 5'd0, rd, v[15:0]), 1'b1, tg);
            else begin
               push(iw(6'h0F, 5'd0, rd, v[31:16]), 1'b0, tg);
               push(iw(6'h0D, rd, rd, v[15:0]), 1'b1, tg);
            end
         end
         default: begin
            push(rw(5'd0, rd, 5'd1, a, 6'd2), 1'b0, (a == 0) ? "R7" : "R6");
            push(rw(5'd0, rd, rd, 5'(6'd32 - {1'b0, a}), 6'd0), 1'b0,
                 (a == 0) ? "R7" : "R6");
            push(rw(rd, 5'd1, rd, 5'd0, 6'd37), 1'b1, "R6");
         end
      endcase
      @(negedge clk); #2;
      in_op = op; in_rd = rd; in_rs = rs; in_value = v; in_valid = 1'b1;
      forever begin
         #2 got = in_ready;
         @(posedge clk);
         if (got) break;
         @(negedge clk); #2;
      end
   endtask

   task automatic idle_wait();
      @(negedge clk); #2;
      in_valid = 1'b0;
      while (exp_q.size() != 0 || out_valid) @(negedge clk);
      #2;
   endtask

   // ready driver
   always begin
      @(negedge clk); #2;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      out_ready = (rdy_mode == 0) ? 1'b1 : lfsr[0];
   end

   // monitor / scoreboard
   bit hold_pend = 1'b0;
   logic [32:0] hold_v;
   bit run_pend = 1'b0;
   always begin
      @(negedge clk); #3;
      if (rst_n) begin
         if (hold_pend)
            chk(out_valid && {out_last, out_word} == hold_v, "R8",
                {out_last, out_word}, hold_v);
         hold_pend = out_valid && !out_ready;
         hold_v = {out_last, out_word};
         if (run_pend && rdy_mode == 0)
            chk(out_valid, "R10", {32'd0, out_valid}, 33'd1);
         run_pend = out_valid && out_ready && !out_last;
         if (out_valid && !(out_ready && out_last))
            chk(!in_ready, "R9", {32'd0, in_ready}, 33'd0);
         else
            chk(in_ready, "R9", {32'd0, in_ready}, 33'd1);
         if (out_valid && out_ready) begin
            if (exp_q.size() == 0)
               chk(1'b0, "R2", {out_last, out_word}, 33'd0);
            else begin
               logic [32:0] e;
               string t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               chk({out_last, out_word} == e, t, {out_last, out_word}, e);
            end
         end
      end
   end

   task automatic run_set();
      send(2'd0, 5'd5, 5'd9, 32'h0);
      send(2'd1, 5'd8, 5'd0, 32'h0000_7FFF);
      send(2'd1, 5'd8, 5'd0, 32'hFFFF_FFFF);
      send(2'd1, 5'd10, 5'd0, 32'h0000_8000);
      send(2'd1, 5'd9, 5'd0, 32'hABAB_CDCD);
      send(2'd1, 5'd11, 5'd0, 32'hFFFF_8000);
      send(2'd2, 5'd4, 5'd0, 32'h0040_0000);
      send(2'd2, 5'd4, 5'd0, 32'h0000_1234);
      send(2'd3, 5'd8, 5'd0, 32'd5);
      send(2'd3, 5'd12, 5'd0, 32'hFFFF_FFE0);
      send(2'd3, 5'd31, 5'd0, 32'd31);
      send(2'd0, 5'd31, 5'd2, 32'hDEAD_BEEF);
      idle_wait();
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #3;
      chk(!out_valid, "R1", {32'd0, out_valid}, 33'd0);
      chk(in_ready, "R1", {32'd0, in_ready}, 33'd1);
      rdy_mode = 0;
      run_set();
      rdy_mode = 1;
      run_set();
      run_set();
      rdy_mode = 0;
      run_set();
      if (!finished) begin
         finished = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_tests++;
         n_fail++;
         $display("FAIL watchdog R10 actual=hung expected=done");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule